// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Clock-Domain Crossing

This block holds the digital control for an 8-bit successive-approximation converter. It spans two unrelated clocks. On the bus side, software writes a control register that holds a channel number and an interrupt enable. It then waits for a completion flag and reads the 8-bit result, which clears the flag. On the conversion side, a sequencer runs a fixed 16-clock cycle. It selects the analog channel, presents trial codes to the converter's DAC, and takes one comparator decision per bit, from the most significant bit down.

A register write starts a conversion. The write moves to the conversion clock through a two-bit Gray-coded request counter and a two-flop synchronizer, and the synchronizer stages count as the first two of the sixteen cycles. A write that arrives while a conversion is running abandons that conversion and starts again on the new channel. The all-ones channel code turns the converter off.

The completed code returns to the bus clock on a toggle. The result register is loaded only when the synchronized toggle changes, so the bus side never samples a code that is still changing.

The block also produces the value read back from eight port pins. Each pin can be taken over by the converter channel of the same number. A configuration flag reports when the channel that shares its pin with a timer clock input is selected while that timer input is enabled.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is in this state: `result` = 0x00, `eoc_flag` = 0, `irq` = 0, `conv_busy` = 0, `trial` = 0x00, `adc_off` = 1. The reset channel is the off code.
- R2: The sequencer tests one bit per conversion clock, MSB first. A bit stays set when `cmp_in` is 1 (input at or above the trial code) and is cleared otherwise.
  - An input at or above full scale gives 0xFF.
  - An input at or below zero gives 0x00.
  - Any other input gives its own 8-bit value.
- R3: Cycle count of a conversion:
  - A conversion takes 16 conversion-clock edges, counted from the first conversion-clock edge after the bus write.
  - `conv_busy` falls and the result is committed on that 16th edge.
  - The count can be 17 when the write lands right next to a conversion-clock edge.
- R4: `trial` does not change while the sequencer is idle (`conv_busy` low).
- R5: `eoc_flag` behaviour:
  - It rises once per finished conversion, in the same bus cycle that `result` takes the new code.
  - A `bus_rd` pulse clears it.
  - A register write also clears it.
- R6: `irq` is high exactly when `eoc_flag` is high and the enable bit written with the channel was 1.
- R7: A write during an active conversion abandons it. Only the conversion on the newly written channel completes and raises the flag.
- R8: Channel code 31 (all ones) sets `adc_off`, starts no conversion, and stops a conversion in progress without a completion.
- R9: Port pin i (i = 0..7) is owned by the converter when `adc_off` is 0 and the channel equals i. A set bit in `port_ddr` means output. The value on `port_rd` is chosen as follows:

  | `port_ddr[i]` | pin owned | `port_rd[i]` |
  |---|---|---|
  | 1 | either | `port_latch[i]` |
  | 0 | yes | 0 |
  | 0 | no | `port_pin[i]` |

- R10: `cfg_err` is 1 exactly when `tmr_ext_clk_en` is 1 and the selected channel is 6.
- R11: While a conversion runs and after it completes, `conv_chan` holds the channel of that conversion. `result` changes only in the cycle that sets `eoc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_wr | input | 1 | Control register write strobe |
| bus_wchan | input | 5 | Channel field of the write (31 = off) |
| bus_wie | input | 1 | Interrupt enable field of the write |
| bus_rd | input | 1 | Result register read strobe, clears the flag |
| result | output | 8 | Last completed conversion code |
| eoc_flag | output | 1 | Conversion complete flag |
| irq | output | 1 | Interrupt request |
| adc_off | output | 1 | Converter powered down |
| tmr_ext_clk_en | input | 1 | Timer is using the shared pin as its clock |
| port_ddr | input | 8 | Pin direction bits, 1 = output |
| port_latch | input | 8 | Port output data latch |
| port_pin | input | 8 | Pin levels |
| port_rd | output | 8 | Port read-back value |
| cfg_err | output | 1 | Forbidden channel/timer combination |
| conv_clk | input | 1 | Conversion clock, asynchronous to bus_clk |
| conv_rst_n | input | 1 | Synchronous active-low reset, conversion domain |
| cmp_in | input | 1 | Comparator decision: input >= trial code |
| trial | output | 8 | Trial code to the DAC |
| conv_chan | output | 5 | Channel presented to the analog multiplexer |
| conv_busy | output | 1 | Conversion in progress |

## Verification
Conversions are run at both rails and beyond them (0, 255, -5, 300). These check the clamping and show whether every bit is kept or cleared. Alternating patterns 0x5A and 0xA5 catch a decision stored in the wrong bit position or with the wrong polarity. The neighbours 127 and 128, and the value 1, isolate the MSB step and the final LSB step. Back-to-back writes separate a correct abort from a stale second completion. An off write, issued both idle and mid-conversion, shows that no completion leaks through. The port read-back is tried with the pin owned and not owned, under both direction settings.

// File: rtl/adc_seq_pkg.sv
// Shared helpers for the converter sequencer.
// Assumes: request counter is two bits wide and Gray coded.
package adc_seq_pkg;

    typedef logic [1:0] gray2_t;

    // Next value of a two-bit Gray counter (00,01,11,10).
    function automatic gray2_t gray_inc(input gray2_t g);
        return {g[0], ~g[1]};
    endfunction

endpackage

// File: rtl/adc_bus_side.sv
// Bus-domain register side: holds the channel/enable register, issues a
// Gray-coded start request per write, and receives completions from the
// conversion domain through a toggle synchronizer.
// Assumes: conv_result is stable whenever the completion toggle moves,
// since completions are at least one conversion length apart.
module adc_bus_side
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int CH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CH_W-1:0]  wchan,
    input  logic             wie,
    input  logic             rd,
    input  logic             cmpl_tgl,
    input  logic [RES_W-1:0] conv_result,
    output logic [CH_W-1:0]  cfg_chan,
    output gray2_t           req_gray,
    output logic [RES_W-1:0] result,
    output logic             flag,
    output logic             irq,
    output logic             adc_off,
    output logic             cmpl_pulse
);

    localparam logic [CH_W-1:0] OFF_CODE = '1;

    logic ie_q;
    logic tg_s1, tg_s2, tg_s3;

    // Control register and start-request counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_chan <= OFF_CODE;
            ie_q     <= 1'b0;
            req_gray <= '0;
        end else if (wr) begin
            cfg_chan <= wchan;
            ie_q     <= wie;
            req_gray <= gray_inc(req_gray);
        end
    end

    // Completion toggle synchronizer with a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tg_s1 <= 1'b0;
            tg_s2 <= 1'b0;
            tg_s3 <= 1'b0;
        end else begin
            tg_s1 <= cmpl_tgl;
            tg_s2 <= tg_s1;
            tg_s3 <= tg_s2;
        end
    end

    assign cmpl_pulse = tg_s2 ^ tg_s3;

    // Result capture and completion flag; a completion outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag   <= 1'b0;
        end else begin
            if (cmpl_pulse) begin
                result <= conv_result;
                flag   <= 1'b1;
            end else if (rd || wr) begin
                flag <= 1'b0;
            end
        end
    end

    assign irq     = flag & ie_q;
    assign adc_off = (cfg_chan == OFF_CODE);

endmodule

// File: rtl/adc_conv_seq.sv
// Conversion-domain sequencer. The two synchronizer stages for the start
// request are counted as steps 1 and 2 of the conversion. Step 3 latches
// the channel, the MSB trial is set after step 6, one decision is taken per
// step through step 14, and the code is committed after step 15.
// Assumes: cfg_chan is stable for two conversion clocks before its request
// change reaches the second synchronizer stage.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 8,
    parameter int CH_W     = 5,
    parameter int CONV_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gray2_t           req_gray,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic [CH_W-1:0]  conv_chan,
    output logic             busy,
    output logic [RES_W-1:0] result_q,
    output logic             cmpl_tgl
);

    localparam int STEP_W     = $clog2(CONV_LEN);
    localparam int IDX_W      = $clog2(RES_W);
    localparam int STEP_FIRST = 3;
    localparam int STEP_MSB   = CONV_LEN - RES_W - 2;
    localparam int STEP_LSB   = STEP_MSB + RES_W;
    localparam int STEP_LAST  = CONV_LEN - 1;
    localparam logic [CH_W-1:0] OFF_CODE = '1;

    gray2_t            rq_s1, rq_s2, rq_seen;
    logic [STEP_W-1:0] step;
    logic              start_det;
    logic              in_win;
    logic [STEP_W-1:0] bit_dist;
    logic [IDX_W-1:0]  bidx;

    // Request change seen at the synchronizer output.
    assign start_det = (rq_s2 != rq_seen);

    // Decision window and the trial bit index it works on.
    always_comb begin
        in_win   = (step > STEP_W'(STEP_MSB)) && (step <= STEP_W'(STEP_LSB));
        bit_dist = STEP_W'(STEP_LSB) - step;
        bidx     = IDX_W'(bit_dist);
    end

    // Request synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_s1 <= '0;
            rq_s2 <= '0;
        end else begin
            rq_s1 <= req_gray;
            rq_s2 <= rq_s1;
        end
    end

    // Step counter, SAR register and result commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_seen   <= '0;
            step      <= '0;
            busy      <= 1'b0;
            trial     <= '0;
            result_q  <= '0;
            cmpl_tgl  <= 1'b0;
            conv_chan <= OFF_CODE;
        end else if (start_det) begin
            rq_seen   <= rq_s2;
            conv_chan <= cfg_chan;
            if (cfg_chan != OFF_CODE) begin
                busy  <= 1'b1;
                step  <= STEP_W'(STEP_FIRST);
                trial <= '0;
            end else begin
                busy <= 1'b0;
            end
        end else if (busy) begin
            step <= step + 1'b1;
            if (step == STEP_W'(STEP_MSB)) begin
                trial[RES_W-1] <= 1'b1;
            end else if (in_win) begin
                trial[bidx] <= cmp_in;
                if (bidx != '0) begin
                    trial[bidx - IDX_W'(1)] <= 1'b1;
                end
            end else if (step == STEP_W'(STEP_LAST)) begin
                result_q <= trial;
                cmpl_tgl <= ~cmpl_tgl;
                busy     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_port_mux.sv
// Port read-back selection for pins that the converter may own, and the
// forbidden-configuration flag for the channel shared with the timer clock.
// Assumes: pin i is tied to converter channel i.
module adc_port_mux #(
    parameter int PORT_W    = 8,
    parameter int CH_W      = 5,
    parameter int SHARED_CH = 6
) (
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              adc_off,
    input  logic              tmr_ext_clk_en,
    input  logic [PORT_W-1:0] ddr,
    input  logic [PORT_W-1:0] latch,
    input  logic [PORT_W-1:0] pin,
    output logic [PORT_W-1:0] port_rd,
    output logic              cfg_err
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic owned;
        // Ownership of this pin by the active converter channel.
        assign owned      = !adc_off && (cfg_chan == CH_W'(i));
        // Read-back: latch for outputs, zero for owned inputs, else pin.
        assign port_rd[i] = ddr[i] ? latch[i] : (owned ? 1'b0 : pin[i]);
    end

    // Shared timer-clock pin selected as a converter input.
    assign cfg_err = tmr_ext_clk_en && (cfg_chan == CH_W'(SHARED_CH));

endmodule

// File: rtl/adc_seq_top.sv
// Top of the converter sequencer: bus register side, conversion-domain
// sequencer and port read-back logic. Two asynchronous clocks, each with
// its own synchronous active-low reset.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 8,
    parameter int CH_W      = 5,
    parameter int CONV_LEN  = 16,
    parameter int PORT_W    = 8,
    parameter int SHARED_CH = 6
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_wr,
    input  logic [CH_W-1:0]   bus_wchan,
    input  logic              bus_wie,
    input  logic              bus_rd,
    output logic [RES_W-1:0]  result,
    output logic              eoc_flag,
    output logic              irq,
    output logic              adc_off,
    input  logic              tmr_ext_clk_en,
    input  logic [PORT_W-1:0] port_ddr,
    input  logic [PORT_W-1:0] port_latch,
    input  logic [PORT_W-1:0] port_pin,
    output logic [PORT_W-1:0] port_rd,
    output logic              cfg_err,
    input  logic              conv_clk,
    input  logic              conv_rst_n,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  trial,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_busy
);

    logic [CH_W-1:0]  cfg_chan;
    gray2_t           req_gray;
    logic [RES_W-1:0] conv_result;
    logic             cmpl_tgl;
    logic             cmpl_bus;

    adc_bus_side #(.RES_W(RES_W), .CH_W(CH_W)) u_bus (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr         (bus_wr),
        .wchan      (bus_wchan),
        .wie        (bus_wie),
        .rd         (bus_rd),
        .cmpl_tgl   (cmpl_tgl),
        .conv_result(conv_result),
        .cfg_chan   (cfg_chan),
        .req_gray   (req_gray),
        .result     (result),
        .flag       (eoc_flag),
        .irq        (irq),
        .adc_off    (adc_off),
        .cmpl_pulse (cmpl_bus)
    );

    adc_conv_seq #(.RES_W(RES_W), .CH_W(CH_W), .CONV_LEN(CONV_LEN)) u_seq (
        .clk      (conv_clk),
        .rst_n    (conv_rst_n),
        .req_gray (req_gray),
        .cfg_chan (cfg_chan),
        .cmp_in   (cmp_in),
        .trial    (trial),
        .conv_chan(conv_chan),
        .busy     (conv_busy),
        .result_q (conv_result),
        .cmpl_tgl (cmpl_tgl)
    );

    adc_port_mux #(.PORT_W(PORT_W), .CH_W(CH_W), .SHARED_CH(SHARED_CH)) u_port (
        .cfg_chan      (cfg_chan),
        .adc_off       (adc_off),
        .tmr_ext_clk_en(tmr_ext_clk_en),
        .ddr           (port_ddr),
        .latch         (port_latch),
        .pin           (port_pin),
        .port_rd       (port_rd),
        .cfg_err       (cfg_err)
    );

endmodule

// File: rtl/adc_seq_chk.sv
// Property checker for the converter sequencer, bound to adc_seq_top.
// Assumes: each reset is held for at least two cycles of its own clock.
module adc_seq_chk #(
    parameter int RES_W = 8,
    parameter int CH_W  = 5
) (
    input logic             bus_clk,
    input logic             bus_rst_n,
    input logic             conv_clk,
    input logic             conv_rst_n,
    input logic             irq,
    input logic             eoc_flag,
    input logic             bus_rd,
    input logic             cmpl_bus,
    input logic [RES_W-1:0] result,
    input logic             conv_busy,
    input logic [CH_W-1:0]  conv_chan,
    input logic [RES_W-1:0] trial
);

    // R6
    irq_needs_flag_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        irq |-> eoc_flag);

    // R5
    read_clears_flag_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_rd && !cmpl_bus) |=> !eoc_flag);

    // R11
    result_with_flag_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !$stable(result) |-> eoc_flag);

    // R8
    off_never_busy_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
        conv_busy |-> (conv_chan != '1));

    // R4
    idle_trial_hold_chk: assert property (@(posedge conv_clk) disable iff (!conv_rst_n)
        !conv_busy |-> $stable(trial));

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .conv_clk  (conv_clk),
    .conv_rst_n(conv_rst_n),
    .irq       (irq),
    .eoc_flag  (eoc_flag),
    .bus_rd    (bus_rd),
    .cmpl_bus  (cmpl_bus),
    .result    (result),
    .conv_busy (conv_busy),
    .conv_chan (conv_chan),
    .trial     (trial)
);

// File: tb/adc_seq_top_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver queues expected completions, the monitor
// pops and compares them whenever the completion flag appears.
module adc_seq_top_test;

    logic       bus_clk = 1'b0;
    logic       conv_clk = 1'b0;
    logic       bus_rst_n = 1'b0;
    logic       conv_rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_wchan = '0;
    logic       bus_wie = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] result;
    logic       eoc_flag, irq, adc_off, cfg_err, conv_busy;
    logic       tmr_ext_clk_en = 1'b0;
    logic [7:0] port_ddr = '0, port_latch = '0, port_pin = '0;
    logic [7:0] port_rd;
    logic       cmp_in;
    logic [7:0] trial;
    logic [4:0] conv_chan;

    int vin = 0;
    int total = 0;
    int bad = 0;
    int cedges = 0;
    int c_wr = 0;
    bit finished = 1'b0;

    typedef struct {
        int ch;
        int res;
        int ie;
    } exp_t;
    exp_t sb[$];

    // Comparator model: decision is input >= trial code.
    assign cmp_in = (vin >= int'(trial));

    always #2 bus_clk = ~bus_clk;
    initial begin
        #1.3;
        forever #18.5 conv_clk = ~conv_clk;
    end
    always @(posedge conv_clk) cedges++;

    adc_seq_top uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr),
        .bus_wchan(bus_wchan), .bus_wie(bus_wie), .bus_rd(bus_rd),
        .result(result), .eoc_flag(eoc_flag), .irq(irq), .adc_off(adc_off),
        .tmr_ext_clk_en(tmr_ext_clk_en), .port_ddr(port_ddr),
        .port_latch(port_latch), .port_pin(port_pin), .port_rd(port_rd),
        .cfg_err(cfg_err), .conv_clk(conv_clk), .conv_rst_n(conv_rst_n),
        .cmp_in(cmp_in), .trial(trial), .conv_chan(conv_chan),
        .conv_busy(conv_busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp8(input int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    task automatic write_ctl(input int ch, input bit ie, input bit push);
        @(negedge bus_clk);
        bus_wchan = 5'(ch);
        bus_wie   = ie;
        bus_wr    = 1'b1;
        if (push) sb.push_back('{ch, clamp8(vin), int'(ie)});
        @(posedge bus_clk);
        c_wr = cedges;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_drain();
        while (sb.size() != 0 || eoc_flag) @(negedge bus_clk);
        repeat (4) @(negedge bus_clk);
    endtask

    task automatic convert(input int ch, input bit ie, input int v);
        vin = v;
        write_ctl(ch, ie, 1'b1);
        wait_drain();
    endtask

    // Monitor: pop the expected item on each completion, compare, then read.
    initial begin
        wait (bus_rst_n);
        forever begin
            @(negedge bus_clk);
            if (eoc_flag) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "completion with nothing pending", result, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(result) == e.res, "R2", "result code", result, e.res);
                    check(int'(conv_chan) == e.ch, "R11", "channel used", conv_chan, e.ch);
                    check(int'(irq) == e.ie, "R6", "irq level", irq, e.ie);
                end
                bus_rd = 1'b1;
                @(negedge bus_clk);
                bus_rd = 1'b0;
                check(!eoc_flag, "R5", "flag after read", eoc_flag, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            check(1'b0, "WD", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit saw;
        bit idle_ok;
        repeat (6) @(negedge conv_clk);
        conv_rst_n = 1'b1;
        @(negedge bus_clk);
        bus_rst_n = 1'b1;
        @(negedge bus_clk);

        // R1 reset state
        check(result == 8'h00, "R1", "result", result, 0);
        check(!eoc_flag, "R1", "flag", eoc_flag, 0);
        check(!irq, "R1", "irq", irq, 0);
        check(!conv_busy, "R1", "busy", conv_busy, 0);
        check(trial == 8'h00, "R1", "trial", trial, 0);
        check(adc_off, "R1", "adc_off", adc_off, 1);

        // R2 codes at rails, beyond rails and bit patterns
        convert(9, 1'b1, 0);
        convert(10, 1'b0, 255);
        convert(11, 1'b1, 300);
        convert(12, 1'b0, -5);
        convert(13, 1'b1, 90);
        convert(1, 1'b1, 165);
        convert(2, 1'b0, 1);
        convert(5, 1'b1, 128);
        convert(0, 1'b0, 127);

        // R3 latency from the write to the commit edge
        vin = 77;
        write_ctl(14, 1'b0, 1'b1);
        saw = 1'b0;
        forever begin
            @(negedge conv_clk);
            if (conv_busy) saw = 1'b1;
            else if (saw) break;
        end
        n = cedges - c_wr;
        check(n == 16 || n == 17, "R3", "conversion edges", n, 16);
        wait_drain();

        // R7 abort by a second write
        vin = 50;
        write_ctl(2, 1'b0, 1'b0);
        repeat (8) @(negedge conv_clk);
        vin = 200;
        write_ctl(3, 1'b1, 1'b1);
        wait_drain();
        repeat (40) @(negedge conv_clk);
        check(conv_chan == 5'd3, "R7", "restarted channel", conv_chan, 3);
        check(!eoc_flag, "R7", "no stale completion", eoc_flag, 0);

        // R9 owned pin 3 (channel 3 selected)
        port_pin = 8'hFF; port_ddr = 8'h00; port_latch = 8'h00;
        #1 check(port_rd == 8'hF7, "R9", "owned input reads 0", port_rd, 8'hF7);
        port_ddr = 8'h08; port_latch = 8'h08;
        #1 check(port_rd == 8'hFF, "R9", "owned output reads latch", port_rd, 8'hFF);
        port_latch = 8'h00;
        #1 check(port_rd == 8'hF7, "R9", "owned output latch 0", port_rd, 8'hF7);

        // R8 power down while idle
        write_ctl(31, 1'b1, 1'b0);
        check(adc_off, "R8", "adc_off set", adc_off, 1);
        idle_ok = 1'b1;
        repeat (40) begin
            @(negedge conv_clk);
            if (conv_busy) idle_ok = 1'b0;
        end
        check(idle_ok, "R8", "no conversion when off", 0, 1);
        check(!eoc_flag, "R8", "no flag when off", eoc_flag, 0);

        // R9 not owned when off
        port_ddr = 8'h00; port_pin = 8'hA5;
        #1 check(port_rd == 8'hA5, "R9", "unowned pins read pin", port_rd, 8'hA5);

        // R8 power down during a conversion
        vin = 100;
        write_ctl(4, 1'b1, 1'b0);
        repeat (6) @(negedge conv_clk);
        write_ctl(31, 1'b1, 1'b0);
        repeat (40) @(negedge conv_clk);
        check(!eoc_flag && !conv_busy, "R8", "aborted by off", eoc_flag, 0);

        // R10 shared-pin conflict
        tmr_ext_clk_en = 1'b1;
        convert(5, 1'b0, 33);
        check(!cfg_err, "R10", "other channel", cfg_err, 0);
        convert(6, 1'b1, 200);
        check(cfg_err, "R10", "shared channel with timer", cfg_err, 1);
        tmr_ext_clk_en = 1'b0;
        #1 check(!cfg_err, "R10", "shared channel no timer", cfg_err, 0);

        // R5 write clears a pending flag (monitor idle: nothing queued)
        check(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule